// File: doc/BRIEF.md
# UART Line Configuration Registers with Busy Interlock

This block is the configuration register file of a 16550-style serial port. It holds the line control byte, the two divisor bytes, the interrupt enables and the modem control byte. It also has a status word and a hold-control word. The baud generator, shift registers and FIFOs sit outside the block. The block sees them only through three activity inputs, and it drives them through plain configuration outputs and a FIFO flush pulse.

Changing the frame format or the baud divisor while a character is on the wire corrupts that character. So, while the port reports activity, writes to the line control byte and to the divisor bytes are normally dropped. Software may instead enable a staged mode. In that mode, such writes land in shadow copies, and a commit request moves the copies into the live registers at the next frame boundary. A loopback request is likewise held back until any character that is being received has finished.

The register bus is a plain one-cycle strobe interface with no back-pressure. A write takes effect at the clock edge that samples `bus_wr`. A read returns `bus_rdata` together with `bus_rvalid` one cycle after `bus_rd`.

Top module: `uart_cfg_regs`

## Requirements
- R1: The port is active when `tx_active`, `rx_active` or `txfifo_nonempty` is high. A read of offset 0x1F returns this activity in bit 0, and its other bits read 0.
- R2: While the port is active and staged mode is off, writes to the line control byte (offset 3) and to the divisor bytes are dropped. A later read of offset 3 returns the old value, and `line_ctrl_o` and `divisor_o` do not change.
- R3: Bit 7 of the line control byte is the divisor-access bit. When it is set, offset 0 reaches the divisor low byte and offset 1 reaches the divisor high byte. When it is clear, offset 1 reaches the interrupt enables (`int_en_o`) and the divisor is untouched. `divisor_o` is {high, low}.
- R4: Bit 0 of the hold-control word (offset 0x1E) enables staged mode. With staged mode on and the port active, writes to the line control byte and to the divisor bytes go to shadow copies, and the live outputs keep their values. Routing at offsets 0 and 1 follows the shadow copy of the divisor-access bit.
- R5: Writing 1 to bit 1 of offset 0x1E while staged mode is on requests a commit. That bit reads 1 until the first cycle in which `tx_active` and `rx_active` are both low. At that edge the shadow values become live, and the bit then reads 0.
- R6: With the parameter COMPAT=1, the interlock is absent. Line control and divisor writes always take effect, and status bit 0 reads 0.
- R7: Bit 4 of the modem control byte (offset 4) requests loopback. `loop_active_o` rises only at an edge where `rx_active` is low. It falls one cycle after the request bit is cleared.
- R8: A write to offset 2 with bit 1 or bit 2 set is accepted even while the port is active. It produces a one-cycle `fifo_flush` pulse in the cycle after the write.
- R9: After reset, all configuration outputs, `loop_active_o` and `fifo_flush` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| tx_active | input | 1 | Transmitter is shifting a character |
| rx_active | input | 1 | Receiver is taking in a character |
| txfifo_nonempty | input | 1 | TX FIFO holds data |
| line_ctrl_o | output | 8 | Live line control byte |
| divisor_o | output | 16 | Live baud divisor |
| int_en_o | output | 8 | Interrupt enables |
| modem_ctrl_o | output | 8 | Modem control byte |
| loop_active_o | output | 1 | Loopback in force; external input cut off |
| fifo_flush | output | 1 | One-cycle pulse that empties both FIFOs |

## Verification
Register writes show on the configuration outputs at the negative edge that follows the sampling edge. Read data is due one cycle after the read strobe, so a scoreboard queue pairs each read with its expected byte when `bus_rvalid` rises. A commit and a loopback request complete at the first edge after the activity input falls, and the bench samples them at the negative edge after that edge. The flush pulse is sampled in the half-cycle after the write edge, and again one cycle later to confirm that it has ended.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] OFS_DIV_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIV_HI = 5'h01;
  localparam logic [ADDR_W-1:0] OFS_FLUSH  = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_LINE   = 5'h03;
  localparam logic [ADDR_W-1:0] OFS_MODEM  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_HOLD   = 5'h1E;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h1F;
  localparam int DIVACC_BIT = 7;
  localparam int LOOP_BIT   = 4;
  localparam int STAGE_EN_BIT = 0;
  localparam int COMMIT_BIT   = 1;
endpackage

// File: rtl/uart_busy_track.sv
module uart_busy_track #(
  parameter bit COMPAT = 1'b0
) (
  input  logic tx_active,
  input  logic rx_active,
  input  logic txfifo_nonempty,
  output logic busy,
  output logic frame_idle
);
  assign frame_idle = !tx_active && !rx_active;
  generate
    if (COMPAT) begin : g_none
      assign busy = 1'b0;
    end else begin : g_track
      assign busy = tx_active || rx_active || txfifo_nonempty;
    end
  endgenerate
endmodule

// File: rtl/uart_line_stage.sv
module uart_line_stage
  import uart_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              frame_idle,
  input  logic              stage_en,
  input  logic              commit_req,
  input  logic              wr_line,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] live_line,
  output logic [DATA_W-1:0] live_lo,
  output logic [DATA_W-1:0] live_hi,
  output logic              shadow_divacc,
  output logic              commit_pend
);
  logic [DATA_W-1:0] sh_line, sh_lo, sh_hi;
  logic direct_ok, shadow_ok, apply_now;

  assign direct_ok = !busy;
  assign shadow_ok = busy && stage_en;
  assign apply_now = commit_pend && frame_idle;
  assign shadow_divacc = sh_line[DIVACC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_line <= '0; live_lo <= '0; live_hi <= '0;
      sh_line <= '0; sh_lo <= '0; sh_hi <= '0;
      commit_pend <= 1'b0;
    end else begin
      if (apply_now) begin
        live_line <= sh_line; live_lo <= sh_lo; live_hi <= sh_hi;
        commit_pend <= 1'b0;
      end
      if (commit_req && stage_en) commit_pend <= 1'b1;
      if (wr_line && (direct_ok || shadow_ok)) sh_line <= wdata;
      if (wr_lo && (direct_ok || shadow_ok)) sh_lo <= wdata;
      if (wr_hi && (direct_ok || shadow_ok)) sh_hi <= wdata;
      if (wr_line && direct_ok) live_line <= wdata;
      if (wr_lo && direct_ok) live_lo <= wdata;
      if (wr_hi && direct_ok) live_hi <= wdata;
    end
  end

  // R2 / R4: while active, live line settings move only through a commit
  a_r2_live_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !apply_now) |=> ($stable(live_line) && $stable(live_lo) && $stable(live_hi)));
  // R5: a pending commit completes at the first idle frame boundary
  a_r5_commit_done: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_now && !(commit_req && stage_en)) |=> !commit_pend);
endmodule

// File: rtl/uart_loop_gate.sv
module uart_loop_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_req,
  input  logic rx_active,
  output logic loop_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loop_on <= 1'b0;
    else if (!loop_req) loop_on <= 1'b0;
    else if (!rx_active) loop_on <= 1'b1;
  end

  // R7: loopback never engages in the middle of a received character
  a_r7_loop_waits_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_on && rx_active) |=> !loop_on);
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_cfg_pkg::*;
#(
  parameter bit COMPAT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic              txfifo_nonempty,
  output logic [DATA_W-1:0] line_ctrl_o,
  output logic [2*DATA_W-1:0] divisor_o,
  output logic [DATA_W-1:0] int_en_o,
  output logic [DATA_W-1:0] modem_ctrl_o,
  output logic              loop_active_o,
  output logic              fifo_flush
);
  logic busy, frame_idle, divacc, commit_pend, stage_en;
  logic [DATA_W-1:0] div_lo, div_hi, rd_mux;
  logic wr_line, wr_lo, wr_hi, wr_ier, wr_hold, flush_hit;

  uart_busy_track #(.COMPAT(COMPAT)) u_busy (
    .tx_active(tx_active), .rx_active(rx_active), .txfifo_nonempty(txfifo_nonempty),
    .busy(busy), .frame_idle(frame_idle));

  assign wr_line = bus_wr && bus_addr == OFS_LINE;
  assign wr_lo   = bus_wr && bus_addr == OFS_DIV_LO && divacc;
  assign wr_hi   = bus_wr && bus_addr == OFS_DIV_HI && divacc;
  assign wr_ier  = bus_wr && bus_addr == OFS_DIV_HI && !divacc;
  assign wr_hold = bus_wr && bus_addr == OFS_HOLD;
  assign flush_hit = bus_wr && bus_addr == OFS_FLUSH && (bus_wdata[1] || bus_wdata[2]);

  uart_line_stage u_stage (
    .clk(clk), .rst_n(rst_n), .busy(busy), .frame_idle(frame_idle),
    .stage_en(stage_en), .commit_req(wr_hold && bus_wdata[COMMIT_BIT]),
    .wr_line(wr_line), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
    .live_line(line_ctrl_o), .live_lo(div_lo), .live_hi(div_hi),
    .shadow_divacc(divacc), .commit_pend(commit_pend));

  assign divisor_o = {div_hi, div_lo};

  uart_loop_gate u_loop (
    .clk(clk), .rst_n(rst_n), .loop_req(modem_ctrl_o[LOOP_BIT]),
    .rx_active(rx_active), .loop_on(loop_active_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_o <= '0; modem_ctrl_o <= '0; stage_en <= 1'b0; fifo_flush <= 1'b0;
    end else begin
      if (wr_ier) int_en_o <= bus_wdata;
      if (bus_wr && bus_addr == OFS_MODEM) modem_ctrl_o <= bus_wdata;
      if (wr_hold) stage_en <= bus_wdata[STAGE_EN_BIT];
      fifo_flush <= flush_hit;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_DIV_LO: rd_mux = divacc ? div_lo : '0;
      OFS_DIV_HI: rd_mux = divacc ? div_hi : int_en_o;
      OFS_LINE:   rd_mux = line_ctrl_o;
      OFS_MODEM:  rd_mux = modem_ctrl_o;
      OFS_HOLD:   rd_mux = {6'b0, commit_pend, stage_en};
      OFS_STAT:   rd_mux = {7'b0, busy};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0; bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R8: flush requests pass regardless of activity
  a_r8_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_hit |=> fifo_flush);
  // R3: offset 1 with divisor access clear reaches the interrupt enables
  a_r3_ier_route: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIV_HI && !divacc) |=> (int_en_o == $past(bus_wdata)));
  generate
    if (!COMPAT) begin : g_stat_chk
      // R1: status bit 0 mirrors the activity inputs
      a_r1_status_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_STAT) |=>
          (bus_rdata[0] == $past(tx_active || rx_active || txfifo_nonempty)));
    end else begin : g_compat_chk
      // R6: no activity ever reported
      a_r6_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> !(busy));
    end
  endgenerate
endmodule

// File: tb/uart_cfg_regs_test.sv
module uart_cfg_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic tx_active = 1'b0, rx_active = 1'b0, txfifo_nonempty = 1'b0;
  logic [7:0] bus_rdata, line_ctrl_o, int_en_o, modem_ctrl_o;
  logic [15:0] divisor_o;
  logic bus_rvalid, loop_active_o, fifo_flush;
  logic [7:0] rdata_c, line_c, ier_c, mcr_c;
  logic [15:0] div_c;
  logic rvalid_c, loop_c, flush_c;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_cfg_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tx_active(tx_active), .rx_active(rx_active), .txfifo_nonempty(txfifo_nonempty),
    .line_ctrl_o(line_ctrl_o), .divisor_o(divisor_o), .int_en_o(int_en_o),
    .modem_ctrl_o(modem_ctrl_o), .loop_active_o(loop_active_o), .fifo_flush(fifo_flush));

  uart_cfg_regs #(.COMPAT(1'b1)) uut_compat (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_c), .bus_rvalid(rvalid_c),
    .tx_active(tx_active), .rx_active(rx_active), .txfifo_nonempty(txfifo_nonempty),
    .line_ctrl_o(line_c), .divisor_o(div_c), .int_en_o(ier_c),
    .modem_ctrl_o(mcr_c), .loop_active_o(loop_c), .fifo_flush(flush_c));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) chk("unexpected read", 32'(bus_rdata), 32'hx);
      else chk(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 line", 32'(line_ctrl_o), 0);
    chk("R9 divisor", 32'(divisor_o), 0);
    chk("R9 ier+mcr", {int_en_o, modem_ctrl_o}, 0);
    chk("R9 loop/flush", {loop_active_o, fifo_flush}, 0);
    // R1 activity status
    rd(5'h1F, 8'h00, "R1 idle status");
    tx_active = 1'b1; rd(5'h1F, 8'h01, "R1 tx status");
    tx_active = 1'b0; rx_active = 1'b1; rd(5'h1F, 8'h01, "R1 rx status");
    rx_active = 1'b0; txfifo_nonempty = 1'b1; rd(5'h1F, 8'h01, "R1 fifo status");
    txfifo_nonempty = 1'b0;
    // R3 divisor routing
    wr(5'h03, 8'h83); wr(5'h00, 8'h34); wr(5'h01, 8'h12);
    chk("R3 divisor", 32'(divisor_o), 32'h1234);
    chk("R3 ier untouched", 32'(int_en_o), 0);
    rd(5'h01, 8'h12, "R3 read div hi");
    wr(5'h03, 8'h03); wr(5'h01, 8'h05);
    chk("R3 ier write", 32'(int_en_o), 32'h05);
    chk("R3 divisor kept", 32'(divisor_o), 32'h1234);
    // R2 blocked while active
    tx_active = 1'b1;
    wr(5'h03, 8'h1B);
    rd(5'h03, 8'h03, "R2 line readback");
    chk("R2 line out", 32'(line_ctrl_o), 32'h03);
    tx_active = 1'b0;
    // R4 staged writes
    wr(5'h1E, 8'h01);
    tx_active = 1'b1;
    wr(5'h03, 8'h87); wr(5'h00, 8'h56); wr(5'h01, 8'h00); wr(5'h03, 8'h07);
    chk("R4 line live", 32'(line_ctrl_o), 32'h03);
    chk("R4 divisor live", 32'(divisor_o), 32'h1234);
    chk("R4 ier kept", 32'(int_en_o), 32'h05);
    // R5 commit at frame boundary
    wr(5'h1E, 8'h03);
    rd(5'h1E, 8'h03, "R5 commit pending");
    chk("R5 line before", 32'(line_ctrl_o), 32'h03);
    tx_active = 1'b0;
    @(negedge clk);
    chk("R5 line after", 32'(line_ctrl_o), 32'h07);
    chk("R5 divisor after", 32'(divisor_o), 32'h0056);
    rd(5'h1E, 8'h01, "R5 commit cleared");
    // R7 loopback waits for rx
    rx_active = 1'b1;
    wr(5'h04, 8'h10);
    chk("R7 mcr", 32'(modem_ctrl_o), 32'h10);
    repeat (3) @(negedge clk);
    chk("R7 loop held", 32'(loop_active_o), 0);
    rx_active = 1'b0;
    @(negedge clk);
    chk("R7 loop on", 32'(loop_active_o), 1);
    wr(5'h04, 8'h00);
    @(negedge clk);
    chk("R7 loop off", 32'(loop_active_o), 0);
    // R8 flush while active
    tx_active = 1'b1; txfifo_nonempty = 1'b1;
    wr(5'h02, 8'h06);
    chk("R8 flush pulse", 32'(fifo_flush), 1);
    @(negedge clk);
    chk("R8 flush ends", 32'(fifo_flush), 0);
    // R6 compat build ignores activity
    wr(5'h1E, 8'h00);
    wr(5'h03, 8'h1B);
    chk("R6 compat line", 32'(line_c), 32'h1B);
    chk("R2 main blocked", 32'(line_ctrl_o), 32'h07);
    rd(5'h1F, 8'h01, "R1 status busy");
    chk("R6 compat status", 32'(rdata_c), 0);
    tx_active = 1'b0; txfifo_nonempty = 1'b0;
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule